// File: doc/BRIEF.md
# Linked-List Pointer-Chasing Read Sequencer

This block follows a chain of buffer blocks kept in an external pipelined SRAM of the zero-bus-turnaround kind. Every word read from the SRAM is the address of the next block. A caller gives a starting pointer and the number of hops to take. The sequencer then issues one read per hop. It captures each returned word the moment it is valid and registers that word straight onto the address bus, so the next access is driven in the cycle that follows the capture. With a read pipeline of two clock edges, dependent reads are therefore spaced three cycles apart, and a walk of H hops takes 3H cycles.

Each fetched pointer is reported on an output strobe. When the walk finishes, a one-cycle done pulse appears, together with the cycle count of the operation. An all-ones pointer is treated as the end of the list: it stops the walk early and raises an end-of-list flag. A busy output tells the caller when a new start is ignored. The block never writes the SRAM. Its write port is held inactive.

Top module: `ptr_chase_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, ptr_valid, end_of_list and sram_re are low and cyc_count is zero.
- R2: A start accepted at a clock edge, with a nonzero hop count and a start pointer that is not all ones, drives sram_re high with sram_addr equal to the start pointer in the cycle that follows that edge.
- R3: sram_re is high for single cycles only, and two successive reads of one walk are issued exactly three cycles apart.
- R4: Read data is captured at the third edge after the edge that issued its read. Every read after the first uses the previously captured word as its address. Each captured word appears on ptr_out with ptr_valid high for one cycle, starting at that capture edge.
- R5: A walk that meets no all-ones pointer performs exactly as many reads as the hop count. done pulses for one cycle at the edge of the final capture, and cyc_count then equals three times the hop count.
- R6: A start with a hop count of zero raises done at the acceptance edge, issues no read, and leaves cyc_count at zero.
- R7: The pointer value with all bits set (8'hFF at the default width) marks the end of the list. If a captured word has this value, the walk ends at that capture edge with done and end_of_list high, after the word has been reported. A start pointer with this value ends at once, with done and end_of_list high, no read, and cyc_count zero. end_of_list stays low on walks that never meet this value.
- R8: busy is high from the acceptance edge until the done edge and is low while done is high. A start that arrives while busy is high has no effect on addresses, reported pointers or timing. A start that arrives in the done cycle is accepted.
- R9: sram_we is never asserted and sram_wdata stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk when not busy |
| start_ptr | input | AW | First block address |
| hop_cnt | input | CW | Number of reads to perform |
| busy | output | 1 | Walk in progress; starts ignored |
| done | output | 1 | One-cycle completion pulse |
| end_of_list | output | 1 | Walk ended on an all-ones pointer |
| cyc_count | output | CW+2 | Cycles taken by the latest walk |
| ptr_valid | output | 1 | ptr_out holds a freshly fetched pointer |
| ptr_out | output | AW | Fetched pointer |
| sram_addr | output | AW | SRAM address |
| sram_re | output | 1 | SRAM read enable |
| sram_we | output | 1 | SRAM write enable (held low) |
| sram_wdata | output | AW | SRAM write data (held zero) |
| sram_rdata | input | AW | SRAM read data |

## Verification
If the internal read-tracking pipeline is off by one stage, the block captures a stale or undriven bus value. The wrong word then shows on ptr_out and as the next sram_addr within three cycles of the first read. A bad hop counter appears as one read too many or too few, and as a done pulse and cyc_count that miss 3H by a multiple of three. If a start is wrongly accepted while busy, sram_addr jumps outside the expected chain at the next edge.

// File: rtl/ptr_chase_pkg.sv
package ptr_chase_pkg;
  function automatic logic [31:0] null_word();
    return 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/pc_rd_tracker.sv
module pc_rd_tracker #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  output logic data_here
);
  logic [RD_LAT-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 1'b0;
    else     stage_q[0] <= issue;
  end

  generate
    for (genvar g = 1; g < RD_LAT; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  assign data_here = stage_q[RD_LAT-1];

  // R3: dependent spacing leaves at most one read in flight
  p_inflight_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_q));
endmodule

// File: rtl/pc_counters.sv
module pc_counters #(
  parameter int CW  = 8,
  parameter int CYW = CW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [CW-1:0]  hops_in,
  input  logic           capture,
  input  logic           running,
  output logic           final_hop,
  output logic [CYW-1:0] elapsed
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      elapsed <= '0;
    end else if (load) begin
      left_q  <= hops_in;
      elapsed <= '0;
    end else begin
      if (capture && left_q != '0) left_q <= left_q - 1'b1;
      if (running) elapsed <= elapsed + 1'b1;
    end
  end

  assign final_hop = (left_q == CW'(1));

  // R5: a capture never happens with no hop remaining
  p_hops_left_r5: assert property (@(posedge clk) disable iff (rst)
    (capture && running) |-> (left_q != '0));
endmodule

// File: rtl/ptr_chase_seq.sv
module ptr_chase_seq #(
  parameter int AW     = 8,
  parameter int CW     = 8,
  parameter int RD_LAT = 2,
  localparam int CYW   = CW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  start_ptr,
  input  logic [CW-1:0]  hop_cnt,
  output logic           busy,
  output logic           done,
  output logic           end_of_list,
  output logic [CYW-1:0] cyc_count,
  output logic           ptr_valid,
  output logic [AW-1:0]  ptr_out,
  output logic [AW-1:0]  sram_addr,
  output logic           sram_re,
  output logic           sram_we,
  output logic [AW-1:0]  sram_wdata,
  input  logic [AW-1:0]  sram_rdata
);
  import ptr_chase_pkg::*;

  localparam logic [AW-1:0] NULL_PTR = null_word()[AW-1:0];

  logic accept, cap_fire, last_hop, rd_null;

  assign accept  = start && !busy;
  assign rd_null = (sram_rdata == NULL_PTR);

  pc_rd_tracker #(.RD_LAT(RD_LAT)) u_track (
    .clk(clk), .rst(rst), .issue(sram_re), .data_here(cap_fire)
  );

  pc_counters #(.CW(CW), .CYW(CYW)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .hops_in(hop_cnt),
    .capture(cap_fire), .running(busy), .final_hop(last_hop),
    .elapsed(cyc_count)
  );

  assign sram_we    = 1'b0;
  assign sram_wdata = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      end_of_list <= 1'b0;
      ptr_valid   <= 1'b0;
      ptr_out     <= '0;
      sram_addr   <= '0;
      sram_re     <= 1'b0;
    end else begin
      sram_re   <= 1'b0;
      ptr_valid <= 1'b0;
      done      <= 1'b0;
      if (accept) begin
        end_of_list <= 1'b0;
        if (hop_cnt == '0) begin
          done <= 1'b1;
        end else if (start_ptr == NULL_PTR) begin
          done        <= 1'b1;
          end_of_list <= 1'b1;
        end else begin
          sram_re   <= 1'b1;
          sram_addr <= start_ptr;
          busy      <= 1'b1;
        end
      end else if (busy && cap_fire) begin
        ptr_valid <= 1'b1;
        ptr_out   <= sram_rdata;
        if (last_hop || rd_null) begin
          done        <= 1'b1;
          busy        <= 1'b0;
          end_of_list <= rd_null;
        end else begin
          sram_re   <= 1'b1;
          sram_addr <= sram_rdata;
        end
      end
    end
  end

  // R3: reads are never closer than three cycles
  p_re_gap1_r3: assert property (@(posedge clk) disable iff (rst)
    sram_re |=> !sram_re);
  p_re_gap2_r3: assert property (@(posedge clk) disable iff (rst)
    sram_re |=> ##1 !sram_re);
  // R4: a continuing walk reuses the captured word as the next address
  p_chase_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cap_fire && !last_hop && !rd_null)
      |=> (sram_re && sram_addr == $past(sram_rdata)));
  // R6: zero hops completes at once without a read
  p_zero_hop_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && hop_cnt == '0) |=> (done && !sram_re));
  // R8: done and busy are exclusive; address frozen between reads
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !cap_fire) |=> $stable(sram_addr));
endmodule

// File: tb/tb_ptr_chase_seq.sv
module tb_ptr_chase_seq;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int CYW = CW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] start_ptr = '0;
  logic [CW-1:0] hop_cnt = '0;
  logic busy, done, end_of_list, ptr_valid, sram_re, sram_we;
  logic [CYW-1:0] cyc_count;
  logic [AW-1:0] ptr_out, sram_addr, sram_wdata;
  logic [AW-1:0] sram_rdata = '0;

  always #4 clk = ~clk;

  ptr_chase_seq #(.AW(AW), .CW(CW), .RD_LAT(2)) dut (
    .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr),
    .hop_cnt(hop_cnt), .busy(busy), .done(done),
    .end_of_list(end_of_list), .cyc_count(cyc_count),
    .ptr_valid(ptr_valid), .ptr_out(ptr_out), .sram_addr(sram_addr),
    .sram_re(sram_re), .sram_we(sram_we), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata)
  );

  // pipelined SRAM: address sampled one edge, data driven the next
  logic [AW-1:0] mem [256];
  logic s1_v = 1'b0;
  logic [AW-1:0] s1_a = '0;
  always @(posedge clk) begin
    s1_v <= sram_re;
    s1_a <= sram_addr;
    if (s1_v) sram_rdata <= mem[s1_a];
  end

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int exp_addr [256];
  int exp_ptr  [256];

  task automatic run_walk(input int p, input int h, input bit inj);
    int n = 0;
    int cur = p;
    bit eol = (p == 255) && (h != 0);
    int tt;
    if (p != 255) begin
      while (n < h) begin
        exp_addr[n] = cur;
        exp_ptr[n]  = mem[cur];
        n++;
        if (mem[cur] == 8'hFF) begin eol = 1; break; end
        cur = mem[cur];
      end
    end
    tt = 3 * n;
    start = 1'b1; start_ptr = AW'(p); hop_cnt = CW'(h);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= tt; t++) begin
      if (t > 0) @(negedge clk);
      if (inj && t == 0 && tt > 0) begin
        start = 1'b1; start_ptr = 8'h11; hop_cnt = 8'd2;
      end else if (inj && t == 1) begin
        start = 1'b0;
      end
      begin
        bit re_e = (t % 3 == 0) && (t / 3 < n);
        bit pv_e = (t > 0) && (t % 3 == 0);
        chk(sram_re == re_e, (t == 0) ? "R2" : "R3", "read enable", sram_re, re_e);
        if (re_e && sram_re)
          chk(sram_addr == exp_addr[t/3][AW-1:0], (t == 0) ? "R2" : "R4",
              "read address", sram_addr, exp_addr[t/3]);
        chk(ptr_valid == pv_e, "R4", "ptr_valid", ptr_valid, pv_e);
        if (pv_e && ptr_valid)
          chk(ptr_out == exp_ptr[t/3-1][AW-1:0], "R4", "ptr_out", ptr_out,
              exp_ptr[t/3-1]);
        chk(done == (t == tt), (h == 0) ? "R6" : "R5", "done", done, t == tt);
        chk(busy == (t < tt), "R8", "busy", busy, t < tt);
        chk(!sram_we && sram_wdata == '0, "R9", "write port", sram_we, 0);
      end
    end
    chk(cyc_count == CYW'(tt), (h == 0) ? "R6" : "R5", "cyc_count", cyc_count, tt);
    chk(end_of_list == eol, "R7", "end_of_list", end_of_list, eol);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      int v = (i * 37 + 11) % 256;
      mem[i] = (v == 255) ? 8'h00 : AW'(v);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ptr_valid && !sram_re && !end_of_list, "R1",
        "in reset", {busy, done, ptr_valid, sram_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ptr_valid && !sram_re && cyc_count == '0, "R1",
        "after reset", {busy, done, ptr_valid, sram_re}, 0);
    // sweep of start pointers and hop counts, back to back (R2 R3 R4 R5 R6 R8)
    foreach (exp_addr[k]) exp_addr[k] = 0;
    for (int s = 0; s < 5; s++) begin
      int sp = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 77 : (s == 3) ? 200 : 254;
      for (int h = 0; h < 8; h++) run_walk(sp, h, 1'b0);
    end
    // start while busy ignored (R8)
    run_walk(3, 4, 1'b1);
    run_walk(90, 6, 1'b1);
    // long walk (R5)
    run_walk(1, 60, 1'b0);
    // null handling (R7)
    mem[50] = 8'hFF;
    mem[20] = 8'd50;
    run_walk(50, 3, 1'b0);
    run_walk(20, 5, 1'b0);
    run_walk(20, 2, 1'b0);
    run_walk(255, 4, 1'b0);
    run_walk(255, 0, 1'b0);
    run_walk(20, 1, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule